// File: doc/BRIEF.md
# Sampling ADC Bus Read and Conversion Interface

This block is the digital side of an 8-bit successive-approximation converter that sits on a microprocessor bus. The processor starts a conversion by pulling chip select and read low together. That same strobe also reads the output latch, so every read returns the result of the conversion before it. A digital value on `sample_i` stands in for the analog input. The track/hold freezes that value on a fixed clock edge after the strobe begins. The block then resolves one result bit per converter clock, MSB first.

`busy_o` is high while a conversion is in progress. The output latch normally takes the new result on the clock edge at which `busy_o` falls. If the bus still holds the strobe low when the last bit is resolved, the block stalls with `busy_o` high. It does not load the latch until chip select or read returns high. The data bus is a tri-state output, modelled as an enable plus a value that is zero while the enable is low.

Top module: `adc_bus_if`

## Requirements
- R1: After reset `busy_o` and `hold_o` are low, and the first read returns 0x00.
- R2: A rising clock edge that sees `cs_ni` and `rd_ni` both low while `busy_o` is low sets `busy_o` high after that edge.
- R3: Counting the start edge as the first, `sample_i` is captured on the third rising edge. `hold_o` goes high after that edge and stays high, together with `busy_o`, until the conversion ends.
- R4: The conversion resolves one bit per edge over the 8 edges that follow the capture edge. With the strobe released, `busy_o` falls after the 8th of those edges, which is the 11th edge counted from the start.
- R5: The result is the captured sample as an unsigned binary value, with bit 7 as the MSB.
- R6: The output latch loads the result on the edge at which `busy_o` falls. A later read returns it on `data_o`.
- R7: If the strobe is still low on the final bit edge, `busy_o` stays high and the latch keeps its old value for as long as the strobe stays low. The load and the fall of `busy_o` happen on the first edge that sees `cs_ni` or `rd_ni` high.
- R8: A read made while a conversion is running returns the previous result unchanged.
- R9: A strobe that occurs while `busy_o` is high neither restarts nor lengthens the conversion.
- R10: `data_oe_o` is high exactly when `cs_ni` and `rd_ni` are both low. While `data_oe_o` is low, `data_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| sample_i | input | 8 | Digital stand-in for the analog input |
| busy_o | output | 1 | Conversion in progress |
| hold_o | output | 1 | Track/hold is holding |
| data_o | output | 8 | Data bus value, zero when not driven |
| data_oe_o | output | 1 | Data bus drive enable |

## Verification
The bench changes `sample_i` on each of the edges around the capture edge, so a design that samples one edge early or one edge late converts the wrong value. All 256 codes are converted and read back on the next strobe. A SAR compare that is off by one, or a latch loaded before the final bit, corrupts the low bits. Reads are also pulsed in the middle of conversions: a design that restarts on them runs past 11 cycles, and one that loads the latch early returns the new value too soon. In the stall runs the strobe is held past the final bit for several lengths. A design that ignores the stall drops `busy_o` or changes the data while the strobe is still low.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACQ,
    ST_CONV,
    ST_STALL
  } seq_state_e;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_bus_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int HOLD_EDGES = 3,
  localparam int IDX_W     = $clog2(DATA_W),
  localparam int ACQ_W     = $clog2(HOLD_EDGES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  output logic             capture_o,
  output logic             step_o,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic             load_o,
  output logic             busy_o,
  output logic             hold_o
);
  seq_state_e       state_q, state_d;
  logic [ACQ_W-1:0] acq_q, acq_d;
  logic [IDX_W-1:0] bit_q, bit_d;
  logic             acq_done, last_bit;

  assign acq_done = (acq_q == ACQ_W'(HOLD_EDGES - 1));
  assign last_bit = (bit_q == '0);

  always_comb begin
    state_d   = state_q;
    acq_d     = acq_q;
    bit_d     = bit_q;
    capture_o = 1'b0;
    step_o    = 1'b0;
    load_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (strobe_i) begin
        state_d = ST_ACQ;
        acq_d   = ACQ_W'(1);
      end
      ST_ACQ: begin
        if (acq_done) begin
          capture_o = 1'b1;
          state_d   = ST_CONV;
          bit_d     = IDX_W'(DATA_W - 1);
        end else begin
          acq_d = acq_q + ACQ_W'(1);
        end
      end
      ST_CONV: begin
        step_o = 1'b1;
        if (last_bit) begin
          if (strobe_i) state_d = ST_STALL;
          else begin
            load_o  = 1'b1;
            state_d = ST_IDLE;
          end
        end else begin
          bit_d = bit_q - IDX_W'(1);
        end
      end
      ST_STALL: if (!strobe_i) begin
        load_o  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      acq_q   <= '0;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      acq_q   <= acq_d;
      bit_q   <= bit_d;
    end
  end

  assign bit_idx_o = bit_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign hold_o    = (state_q == ST_CONV) || (state_q == ST_STALL);
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              step_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  output logic [DATA_W-1:0] result_nxt_o
);
  logic [DATA_W-1:0] held_q, sar_q, sar_d, bit_sel, trial;

  for (genvar g = 0; g < DATA_W; g++) begin : g_sel
    assign bit_sel[g] = (bit_idx_i == IDX_W'(g));
  end

  assign trial = sar_q | bit_sel;

  always_comb begin
    sar_d = sar_q;
    if (capture_i) sar_d = '0;
    else if (step_i && (held_q >= trial)) sar_d = trial;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= '0;
      sar_q  <= '0;
    end else begin
      if (capture_i) held_q <= sample_i;
      sar_q <= sar_d;
    end
  end

  assign result_nxt_o = sar_d;
endmodule

// File: rtl/adc_out_latch.sv
module adc_out_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              drive_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  logic [DATA_W-1:0] latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     latch_q <= '0;
    else if (load_i) latch_q <= result_i;
  end

  assign data_oe_o = drive_i;
  assign data_o    = drive_i ? latch_q : '0;
endmodule

// File: rtl/adc_bus_if.sv
module adc_bus_if #(
  parameter int DATA_W     = 8,
  parameter int HOLD_EDGES = 3,
  localparam int IDX_W     = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic [DATA_W-1:0] sample_i,
  output logic              busy_o,
  output logic              hold_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  logic             strobe, capture, step, load;
  logic [IDX_W-1:0] bit_idx;
  logic [DATA_W-1:0] result_nxt;

  assign strobe = ~cs_ni & ~rd_ni;

  adc_seq_ctrl #(.DATA_W(DATA_W), .HOLD_EDGES(HOLD_EDGES)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_i  (strobe),
    .capture_o (capture),
    .step_o    (step),
    .bit_idx_o (bit_idx),
    .load_o    (load),
    .busy_o    (busy_o),
    .hold_o    (hold_o)
  );

  adc_sar_core #(.DATA_W(DATA_W)) u_sar (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .capture_i    (capture),
    .sample_i     (sample_i),
    .step_i       (step),
    .bit_idx_i    (bit_idx),
    .result_nxt_o (result_nxt)
  );

  adc_out_latch #(.DATA_W(DATA_W)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .result_i  (result_nxt),
    .drive_i   (strobe),
    .data_o    (data_o),
    .data_oe_o (data_oe_o)
  );
endmodule

// File: rtl/adc_bus_if_chk.sv
module adc_bus_if_chk #(
  parameter int DATA_W     = 8,
  parameter int HOLD_EDGES = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              rd_ni,
  input logic              busy_o,
  input logic              hold_o,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o
);
  logic [15:0] acq_cnt, conv_cnt;
  logic        strb;

  assign strb = !cs_ni && !rd_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acq_cnt  <= '0;
      conv_cnt <= '0;
    end else begin
      if (!busy_o) begin
        acq_cnt  <= '0;
        conv_cnt <= '0;
      end else if (!hold_o) begin
        acq_cnt <= acq_cnt + 16'd1;
      end else if (conv_cnt != 16'hffff) begin
        conv_cnt <= conv_cnt + 16'd1;
      end
    end
  end

  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && strb) |=> busy_o);

  assert_hold_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |-> (acq_cnt == 16'(HOLD_EDGES - 1)));

  assert_hold_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> busy_o);

  assert_conv_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (conv_cnt >= 16'(DATA_W)));

  assert_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && hold_o && strb) |=> busy_o);

  assert_fall_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(cs_ni || rd_ni));

  assert_read_prev_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && strb) |=> (!(busy_o && data_oe_o) || data_o == $past(data_o)));

  assert_idle_bus_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == '0));
endmodule

bind adc_bus_if adc_bus_if_chk #(.DATA_W(DATA_W), .HOLD_EDGES(HOLD_EDGES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .rd_ni     (rd_ni),
  .busy_o    (busy_o),
  .hold_o    (hold_o),
  .data_o    (data_o),
  .data_oe_o (data_oe_o)
);

// File: tb/adc_bus_if_test.sv
`timescale 1ns/1ps
module adc_bus_if_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1;
  logic       rd_ni = 1'b1;
  logic [7:0] sample_i = 8'h00;
  logic       busy_o, hold_o, data_oe_o;
  logic [7:0] data_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [7:0] prev_res = 8'h00;

  always #10 clk_i = ~clk_i;

  adc_bus_if uut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_ni     (cs_ni),
    .rd_ni     (rd_ni),
    .sample_i  (sample_i),
    .busy_o    (busy_o),
    .hold_o    (hold_o),
    .data_o    (data_o),
    .data_oe_o (data_oe_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One conversion of v: reads the previous result at the start strobe.
  task automatic convert(input logic [7:0] v, input int stall_n, input bit pulse);
    @(negedge clk_i);
    cs_ni = 1'b0; rd_ni = 1'b0; sample_i = ~v;
    #1;
    chk("R10 oe on strobe", data_oe_o, 1);
    chk("R6 read prev result", data_o, prev_res);
    chk("R2 idle before start", busy_o, 0);
    @(negedge clk_i);                          // after edge 1
    chk("R2 busy after start", busy_o, 1);
    chk("R3 track at edge1", hold_o, 0);
    sample_i = v ^ 8'h5a;
    @(negedge clk_i);                          // after edge 2
    chk("R3 track at edge2", hold_o, 0);
    sample_i = v;
    @(negedge clk_i);                          // after edge 3
    chk("R3 hold after edge3", hold_o, 1);
    sample_i = v + 8'd37;
    if (stall_n == 0) begin
      cs_ni = 1'b1; rd_ni = 1'b1;
      #1;
      chk("R10 oe off", data_oe_o, 0);
      chk("R10 bus zero", data_o, 0);
    end
    for (int k = 4; k <= 10; k++) begin
      @(negedge clk_i);                        // after edge k
      if (pulse && k == 5) begin
        cs_ni = 1'b0; rd_ni = 1'b0;
        #1;
        chk("R8 read during conv", data_o, prev_res);
        chk("R10 oe mid read", data_oe_o, 1);
      end
      if (pulse && k == 6) begin
        cs_ni = 1'b1; rd_ni = 1'b1;
      end
      if (k == 10) begin
        chk("R4 busy before last bit", busy_o, 1);
        chk("R9 hold kept", hold_o, 1);
      end
    end
    @(negedge clk_i);                          // after edge 11
    if (stall_n == 0) begin
      chk("R4 busy falls edge11", busy_o, 0);
      chk("R9 no restart", hold_o, 0);
    end else begin
      chk("R7 stall busy", busy_o, 1);
      for (int s = 0; s < stall_n; s++) begin
        @(negedge clk_i);
        chk("R7 busy held in stall", busy_o, 1);
        chk("R7 latch not loaded", data_o, prev_res);
      end
      cs_ni = 1'b1; rd_ni = 1'b1;
      @(negedge clk_i);
      chk("R7 busy falls after release", busy_o, 0);
    end
    prev_res = v;
  endtask

  initial begin : watchdog
    while (cycles < 200000) begin
      @(posedge clk_i);
      cycles++;
    end
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected<200000", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    #35;
    chk("R1 busy at reset", busy_o, 0);
    chk("R1 hold at reset", hold_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 busy after reset", busy_o, 0);
    chk("R10 oe idle", data_oe_o, 0);
    // first read returns reset value 0 (R1), then R5 sweep
    for (int v = 0; v < 256; v++) begin
      convert(8'(v), 0, (v % 3) == 1);
    end
    // stall cases
    convert(8'hc3, 1, 1'b0);
    convert(8'h3c, 4, 1'b0);
    convert(8'hff, 2, 1'b0);
    convert(8'h01, 7, 1'b0);
    convert(8'h80, 0, 1'b1);
    convert(8'h00, 0, 1'b0);
    chk("R5 final readback", prev_res, 8'h00);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule